// File: doc/BRIEF.md
# KCS Host Interface Controller

This block is the host-facing end of a keyboard-controller-style management channel. A host reaches it through two byte registers on a narrow I/O port. Offset 0 carries data in both directions. Offset 1 reads back a status byte, and a write to offset 1 is taken as a control code. A two-bit transfer state sits in the status byte. The host walks that state through idle, write, read and error using a handshake: it writes a byte, waits for the input-full flag to drop, and reads a byte once the output-full flag is set.

In the write phase the block gathers the request bytes into a local buffer. After the closing byte it raises a one-cycle request strobe toward the management backend. The strobe carries the request length and a tag, and the backend fetches the bytes through a read port. The backend returns its answer as a byte stream marked with that tag. The block keeps the answer only when the tag matches the outstanding one. It then hands the answer to the host one byte per read request.

One level interrupt is shared by two sources: fresh output data and a backend attention signal. The interrupt stays high while either source is pending.

Top module: `kcs_host_ctrl`

## Requirements
- R1: After reset the status byte reads 0x00 (state idle, every flag clear), the response tag is 0, the interrupt output is low and no request strobe is active.
- R2: The status byte has output-full in bit 0, input-full in bit 1, attention in bit 2, command/data in bit 3 (1 after a write to offset 1, 0 after a write to offset 0) and the state in bits 7:6. Any accepted write sets input-full on the next clock. The flag clears one clock later once the byte is handled. Writes that arrive while input-full is set are dropped.
- R3: The state codes are idle=0, read=1, write=2 and error=3. Control code 0x61 written in idle moves the block to write, clears the request length and sets output-full.
- R4: In the write state each data byte is appended to the request buffer and sets output-full. After control code 0x62, the next data byte is the final one. It issues a one-clock request strobe that carries the byte count and the current tag, and input-full stays set until the response arrives.
- R5: Request bytes beyond the buffer depth are not stored, but they are still counted in the reported length.
- R6: A response stream is accepted only while a request is outstanding and only when its tag equals the current tag; any other stream is ignored. On acceptance the tag increments and the state becomes read. The first response byte is placed in the data-out register, output-full is set and input-full clears.
- R7: In the read state, data byte 0x68 returns the next response byte and sets output-full. Once every byte has been returned, the next request moves the block to idle and sets output-full. Any other byte or command in the read state moves the block to error with completion status 0x02.
- R8: A response longer than the buffer depth is returned as its first two bytes followed by 0xCA.
- R9: Control code 0x60 outside the error state increments the tag, loads completion status 0x01, enters error and sets output-full. In the error state it has no effect. A data byte written in error switches to read and returns the completion status byte.
- R10: An unrecognised control code for the current state loads completion status 0x02 and enters error without setting output-full.
- R11: Reading offset 0 returns the data-out byte and clears output-full. Reading offset 1 returns the status and clears a pending attention interrupt.
- R12: While the interrupt enable input is high, setting output-full or raising attention with its interrupt request marks that source pending. The interrupt output is high while any source is pending, and it never rises while the enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hst_wr_i | input | 1 | Host write strobe |
| hst_rd_i | input | 1 | Host read strobe (side effects at the clock edge) |
| hst_addr_i | input | 1 | Register offset: 0 data, 1 status/command |
| hst_wdata_i | input | 8 | Host write data |
| hst_rdata_o | output | 8 | Read data for the selected offset |
| irq_en_i | input | 1 | Interrupt enable |
| irq_o | output | 1 | Shared level interrupt |
| req_valid_o | output | 1 | One-clock request strobe toward the backend |
| req_tag_o | output | TAG_W | Tag of the outstanding request |
| req_len_o | output | LEN_W | Request byte count, including bytes past the buffer depth |
| req_raddr_i | input | AW | Backend read address into the request buffer |
| req_rdata_o | output | 8 | Request byte at req_raddr_i |
| rsp_valid_i | input | 1 | Response byte valid |
| rsp_tag_i | input | TAG_W | Tag carried by the response |
| rsp_data_i | input | 8 | Response byte |
| rsp_last_i | input | 1 | Marks the final response byte |
| atn_we_i | input | 1 | Attention update strobe |
| atn_val_i | input | 1 | New attention flag value |
| atn_irq_i | input | 1 | Attention update also requests an interrupt |

## Verification
The bench builds the block with a buffer depth of 4 and a 2-bit tag. With a depth of 4, a seven-byte request shows byte counting past the buffer end, and a six-byte response shows the truncation to two bytes plus 0xCA, without long streams. With a 2-bit tag, the tag wraps after four transactions, so an abort taken at tag 3 shows the wrap to 0. The following request's tag confirms that a second abort given in the error state left the tag alone.

// File: rtl/kcs_pkg.sv
package kcs_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_WRITE = 2'd2,
    ST_ERROR = 2'd3
  } kcs_state_e;

  localparam logic [7:0] CMD_ABORT  = 8'h60;
  localparam logic [7:0] CMD_WSTART = 8'h61;
  localparam logic [7:0] CMD_WEND   = 8'h62;
  localparam logic [7:0] DAT_READ   = 8'h68;

  localparam logic [7:0] ERR_ABORT  = 8'h01;
  localparam logic [7:0] ERR_BADCC  = 8'h02;
  localparam logic [7:0] CC_TRUNC   = 8'hCA;
endpackage

// File: rtl/kcs_buf.sv
module kcs_buf #(
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [7:0]    wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [7:0]    rdata_o
);
  logic [7:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/kcs_irq.sv
module kcs_irq #(
  parameter bit USE_IRQ = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic obf_set_i,
  input  logic obf_clr_i,
  input  logic atn_set_i,
  input  logic atn_clr_i,
  output logic irq_o
);
  if (USE_IRQ) begin : g_irq
    logic obf_p_q, atn_p_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        obf_p_q <= 1'b0;
        atn_p_q <= 1'b0;
      end else begin
        // a new source event wins over a same-cycle clear
        if (obf_set_i && en_i)      obf_p_q <= 1'b1;
        else if (obf_clr_i)         obf_p_q <= 1'b0;
        if (atn_set_i && en_i)      atn_p_q <= 1'b1;
        else if (atn_clr_i)         atn_p_q <= 1'b0;
      end
    end

    assign irq_o = obf_p_q | atn_p_q;
  end else begin : g_noirq
    assign irq_o = 1'b0;
  end
endmodule

// File: rtl/kcs_host_ctrl.sv
module kcs_host_ctrl
  import kcs_pkg::*;
#(
  parameter int DEPTH   = 64,
  parameter int TAG_W   = 8,
  parameter bit USE_IRQ = 1'b1,
  localparam int AW     = $clog2(DEPTH),
  localparam int LEN_W  = AW + 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             hst_wr_i,
  input  logic             hst_rd_i,
  input  logic             hst_addr_i,
  input  logic [7:0]       hst_wdata_i,
  output logic [7:0]       hst_rdata_o,
  input  logic             irq_en_i,
  output logic             irq_o,
  output logic             req_valid_o,
  output logic [TAG_W-1:0] req_tag_o,
  output logic [LEN_W-1:0] req_len_o,
  input  logic [AW-1:0]    req_raddr_i,
  output logic [7:0]       req_rdata_o,
  input  logic             rsp_valid_i,
  input  logic [TAG_W-1:0] rsp_tag_i,
  input  logic [7:0]       rsp_data_i,
  input  logic             rsp_last_i,
  input  logic             atn_we_i,
  input  logic             atn_val_i,
  input  logic             atn_irq_i
);
  localparam logic [LEN_W-1:0] DEPTH_L = LEN_W'(DEPTH);
  localparam logic [LEN_W-1:0] TRUNC_L = LEN_W'(3);
  localparam logic [LEN_W-1:0] LEN_MAX = '1;

  kcs_state_e       state_q, st_d;
  logic             obf_q, ibf_q, cd_q, atn_q, pend_q;
  logic [7:0]       din_q, cmd_q;
  logic             din_v_q, cmd_v_q;
  logic             wend_q, wait_q, err_q, trunc_q;
  logic [7:0]       errc_q, dout_q;
  logic [LEN_W-1:0] inlen_q, outlen_q, outpos_q, rsp_cnt_q;
  logic [TAG_W-1:0] tag_q;
  logic             req_valid_q;
  logic [7:0]       stat_w;

  logic wr_acc, dat_rd, sts_rd, rsp_hit, commit;
  logic [LEN_W-1:0] rsp_tot;
  logic [AW-1:0]    obuf_ra;
  logic [7:0]       obuf_rd, obyte, first_byte;

  assign wr_acc  = hst_wr_i && !ibf_q;
  assign dat_rd  = hst_rd_i && !hst_addr_i;
  assign sts_rd  = hst_rd_i && hst_addr_i;
  assign rsp_hit = rsp_valid_i && wait_q && (rsp_tag_i == tag_q);
  assign commit  = rsp_hit && rsp_last_i;
  assign rsp_tot = rsp_cnt_q + LEN_W'(1);

  assign stat_w      = {state_q, 2'b00, cd_q, atn_q, ibf_q, obf_q};
  assign hst_rdata_o = hst_addr_i ? stat_w : dout_q;

  // buffers
  kcs_buf #(.DEPTH(DEPTH)) u_ibuf (
    .clk_i   (clk_i),
    .we_i    (pend_q && din_v_q && state_q == ST_WRITE && inlen_q < DEPTH_L),
    .waddr_i (inlen_q[AW-1:0]),
    .wdata_i (din_q),
    .raddr_i (req_raddr_i),
    .rdata_o (req_rdata_o)
  );

  assign obuf_ra = commit ? '0 : outpos_q[AW-1:0];

  kcs_buf #(.DEPTH(DEPTH)) u_obuf (
    .clk_i   (clk_i),
    .we_i    (rsp_hit && rsp_cnt_q < DEPTH_L),
    .waddr_i (rsp_cnt_q[AW-1:0]),
    .wdata_i (rsp_data_i),
    .raddr_i (obuf_ra),
    .rdata_o (obuf_rd)
  );

  // byte the host sees next: status code, truncation code or stored byte
  always_comb begin
    if (err_q)                                obyte = errc_q;
    else if (trunc_q && outpos_q == TRUNC_L - LEN_W'(1)) obyte = CC_TRUNC;
    else                                      obyte = obuf_rd;
  end

  assign first_byte = (rsp_cnt_q == '0) ? rsp_data_i : obuf_rd;

  // host byte processing
  logic       p_set_obf, p_clr_ibf, p_tag_inc, p_ld_err, p_app, p_clr_in;
  logic       p_wend_set, p_wend_clr, p_issue, p_adv;
  logic [7:0] p_errc;
  logic       do_rd, rd_ok, cmd_used, skip_chk;

  always_comb begin
    st_d       = state_q;
    p_set_obf  = 1'b0;
    p_clr_ibf  = 1'b0;
    p_tag_inc  = 1'b0;
    p_ld_err   = 1'b0;
    p_errc     = ERR_BADCC;
    p_app      = 1'b0;
    p_clr_in   = 1'b0;
    p_wend_set = 1'b0;
    p_wend_clr = 1'b0;
    p_issue    = 1'b0;
    p_adv      = 1'b0;
    do_rd      = 1'b0;
    cmd_used   = 1'b0;
    skip_chk   = 1'b0;
    rd_ok      = (state_q == ST_ERROR) || (din_v_q && din_q == DAT_READ);
    if (pend_q) begin
      p_clr_ibf = 1'b1;
      if (cmd_v_q && cmd_q == CMD_ABORT) begin
        if (state_q != ST_ERROR) begin
          p_tag_inc = 1'b1;
          p_ld_err  = 1'b1;
          p_errc    = ERR_ABORT;
          st_d      = ST_ERROR;
          p_set_obf = 1'b1;
        end
      end else begin
        case (state_q)
          ST_IDLE: begin
            if (cmd_v_q && cmd_q == CMD_WSTART) begin
              st_d       = ST_WRITE;
              p_clr_in   = 1'b1;
              p_wend_clr = 1'b1;
              p_set_obf  = 1'b1;
              cmd_used   = 1'b1;
            end
          end
          ST_READ: do_rd = 1'b1;
          ST_WRITE: begin
            p_app = din_v_q;
            if (wend_q) begin
              // final byte: hand off, keep input-full until the response
              p_issue    = 1'b1;
              p_wend_clr = 1'b1;
              p_clr_ibf  = 1'b0;
              skip_chk   = 1'b1;
            end else begin
              if (cmd_v_q && cmd_q == CMD_WEND) begin
                cmd_used   = 1'b1;
                p_wend_set = 1'b1;
              end
              p_set_obf = 1'b1;
            end
          end
          ST_ERROR: begin
            if (din_v_q) begin
              st_d  = ST_READ;
              do_rd = 1'b1;
            end
          end
          default: ;
        endcase
        if (do_rd) begin
          if (outpos_q >= outlen_q) begin
            st_d      = ST_IDLE;
            p_set_obf = 1'b1;
          end else if (rd_ok) begin
            p_adv     = 1'b1;
            p_set_obf = 1'b1;
          end else begin
            p_ld_err  = 1'b1;
            st_d      = ST_ERROR;
            p_set_obf = 1'b1;
            skip_chk  = 1'b1;
          end
        end
        if (cmd_v_q && !cmd_used && !skip_chk) begin
          p_ld_err = 1'b1;
          p_errc   = ERR_BADCC;
          st_d     = ST_ERROR;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      obf_q       <= 1'b0;
      ibf_q       <= 1'b0;
      cd_q        <= 1'b0;
      atn_q       <= 1'b0;
      pend_q      <= 1'b0;
      din_q       <= '0;
      cmd_q       <= '0;
      din_v_q     <= 1'b0;
      cmd_v_q     <= 1'b0;
      wend_q      <= 1'b0;
      wait_q      <= 1'b0;
      err_q       <= 1'b0;
      trunc_q     <= 1'b0;
      errc_q      <= '0;
      dout_q      <= '0;
      inlen_q     <= '0;
      outlen_q    <= '0;
      outpos_q    <= '0;
      rsp_cnt_q   <= '0;
      tag_q       <= '0;
      req_valid_q <= 1'b0;
    end else begin
      if (wr_acc) begin
        if (hst_addr_i) begin
          cmd_q   <= hst_wdata_i;
          cmd_v_q <= 1'b1;
          din_v_q <= 1'b0;
        end else begin
          din_q   <= hst_wdata_i;
          din_v_q <= 1'b1;
          cmd_v_q <= 1'b0;
        end
        cd_q   <= hst_addr_i;
        pend_q <= 1'b1;
      end else if (pend_q) begin
        pend_q  <= 1'b0;
        din_v_q <= 1'b0;
        cmd_v_q <= 1'b0;
      end

      if (wr_acc)                            ibf_q <= 1'b1;
      else if ((pend_q && p_clr_ibf) || commit) ibf_q <= 1'b0;

      state_q <= commit ? ST_READ : st_d;

      if (p_set_obf || commit) obf_q <= 1'b1;
      else if (dat_rd)         obf_q <= 1'b0;

      if (atn_we_i) atn_q <= atn_val_i;

      if (p_tag_inc || commit) tag_q <= tag_q + TAG_W'(1);

      if (p_wend_set)      wend_q <= 1'b1;
      else if (p_wend_clr) wend_q <= 1'b0;

      if (p_clr_in)                       inlen_q <= '0;
      else if (p_app && inlen_q != LEN_MAX) inlen_q <= inlen_q + LEN_W'(1);

      if (p_issue)     wait_q <= 1'b1;
      else if (commit) wait_q <= 1'b0;

      req_valid_q <= p_issue;

      if (commit) begin
        err_q    <= 1'b0;
        trunc_q  <= (rsp_tot > DEPTH_L);
        outlen_q <= (rsp_tot > DEPTH_L) ? TRUNC_L : rsp_tot;
        outpos_q <= LEN_W'(1);
        dout_q   <= first_byte;
      end else if (p_ld_err) begin
        err_q    <= 1'b1;
        errc_q   <= p_errc;
        trunc_q  <= 1'b0;
        outlen_q <= LEN_W'(1);
        outpos_q <= '0;
      end else if (p_adv) begin
        dout_q   <= obyte;
        outpos_q <= outpos_q + LEN_W'(1);
      end else if (p_issue) begin
        outlen_q <= '0;
        outpos_q <= '0;
      end

      if (rsp_hit) begin
        if (rsp_last_i)             rsp_cnt_q <= '0;
        else if (rsp_cnt_q < DEPTH_L) rsp_cnt_q <= rsp_cnt_q + LEN_W'(1);
      end
    end
  end

  assign req_valid_o = req_valid_q;
  assign req_tag_o   = tag_q;
  assign req_len_o   = inlen_q;

  kcs_irq #(.USE_IRQ(USE_IRQ)) u_irq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (irq_en_i),
    .obf_set_i (p_set_obf || commit),
    .obf_clr_i (dat_rd),
    .atn_set_i (atn_we_i && atn_val_i && atn_irq_i),
    .atn_clr_i ((atn_we_i && !atn_val_i) || sts_rd),
    .irq_o     (irq_o)
  );
endmodule

// File: rtl/kcs_host_ctrl_chk.sv
module kcs_host_ctrl_chk #(
  parameter int TAG_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             hst_wr_i,
  input logic             irq_en_i,
  input logic             irq_o,
  input logic             req_valid_o,
  input logic             rsp_valid_i,
  input logic [7:0]       stat,
  input logic [TAG_W-1:0] tag,
  input logic             pend,
  input logic [7:0]       cmd,
  input logic [7:0]       din
);
  // R2
  ibf_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!stat[1] && hst_wr_i) |=> stat[1]);

  // R2
  wr_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat[1] && hst_wr_i) |=> ($stable(cmd) && $stable(din)));

  // R4
  issue_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o |-> (stat[1] && stat[7:6] == 2'd2));

  // R12
  irq_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(irq_en_i));

  // R6
  tag_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(tag) |-> $past(rsp_valid_i || pend));

  // R3
  obf_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(stat[0]) |-> $past(pend || rsp_valid_i));

  // R7
  idle_exit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat[7:6] == 2'd0) |=> (stat[7:6] != 2'd1));
endmodule

bind kcs_host_ctrl kcs_host_ctrl_chk #(.TAG_W(TAG_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .hst_wr_i    (hst_wr_i),
  .irq_en_i    (irq_en_i),
  .irq_o       (irq_o),
  .req_valid_o (req_valid_o),
  .rsp_valid_i (rsp_valid_i),
  .stat        (stat_w),
  .tag         (tag_q),
  .pend        (pend_q),
  .cmd         (cmd_q),
  .din         (din_q)
);

// File: tb/kcs_host_ctrl_test.sv
module kcs_host_ctrl_test;
  localparam int DEPTH = 4;
  localparam int TAG_W = 2;
  localparam int AW    = $clog2(DEPTH);
  localparam int LEN_W = AW + 2;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             hst_wr_i = 1'b0, hst_rd_i = 1'b0, hst_addr_i = 1'b0;
  logic [7:0]       hst_wdata_i = '0;
  logic [7:0]       hst_rdata_o;
  logic             irq_en_i = 1'b1;
  logic             irq_o;
  logic             req_valid_o;
  logic [TAG_W-1:0] req_tag_o;
  logic [LEN_W-1:0] req_len_o;
  logic [AW-1:0]    req_raddr_i = '0;
  logic [7:0]       req_rdata_o;
  logic             rsp_valid_i = 1'b0, rsp_last_i = 1'b0;
  logic [TAG_W-1:0] rsp_tag_i = '0;
  logic [7:0]       rsp_data_i = '0;
  logic             atn_we_i = 1'b0, atn_val_i = 1'b0, atn_irq_i = 1'b0;

  int n_chk = 0, n_bad = 0;
  int req_cnt = 0;
  logic [TAG_W-1:0] req_tag_s;
  logic [LEN_W-1:0] req_len_s;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;

  kcs_host_ctrl #(.DEPTH(DEPTH), .TAG_W(TAG_W), .USE_IRQ(1'b1)) uut (
    .clk_i, .rst_ni, .hst_wr_i, .hst_rd_i, .hst_addr_i, .hst_wdata_i,
    .hst_rdata_o, .irq_en_i, .irq_o, .req_valid_o, .req_tag_o, .req_len_o,
    .req_raddr_i, .req_rdata_o, .rsp_valid_i, .rsp_tag_i, .rsp_data_i,
    .rsp_last_i, .atn_we_i, .atn_val_i, .atn_irq_i
  );

  always @(posedge clk_i) begin
    if (req_valid_o) begin
      req_cnt   <= req_cnt + 1;
      req_tag_s <= req_tag_o;
      req_len_s <= req_len_o;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic put(input logic a, input logic [7:0] d);
    hst_wr_i = 1'b1; hst_addr_i = a; hst_wdata_i = d;
    @(negedge clk_i);
    hst_wr_i = 1'b0;
    @(negedge clk_i);
  endtask

  task automatic get(input logic a, output logic [7:0] d);
    hst_addr_i = a; hst_rd_i = 1'b1;
    #1 d = hst_rdata_o;
    @(negedge clk_i);
    hst_rd_i = 1'b0;
  endtask

  task automatic stat_is(input string req, input int exp);
    hst_addr_i = 1'b1;
    #1 check(req, hst_rdata_o, exp);
  endtask

  task automatic data_is(input string req, input int exp);
    logic [7:0] d;
    get(1'b0, d);
    check(req, d, exp);
  endtask

  task automatic drain;
    logic [7:0] d;
    get(1'b0, d);
  endtask

  task automatic send(input logic [TAG_W-1:0] t, input int n, input logic [7:0] base);
    for (int i = 0; i < n; i++) begin
      rsp_valid_i = 1'b1; rsp_tag_i = t; rsp_data_i = base + 8'(i);
      rsp_last_i = (i == n - 1);
      @(negedge clk_i);
    end
    rsp_valid_i = 1'b0; rsp_last_i = 1'b0;
  endtask

  task automatic ibyte_is(input string req, input int idx, input int exp);
    req_raddr_i = AW'(idx);
    #1 check(req, req_rdata_o, exp);
  endtask

  task automatic t_reset;
    stat_is("R1 status", 8'h00);
    check("R1 irq", irq_o, 0);
    check("R1 strobe", req_valid_o, 0);
  endtask

  task automatic t_transfer;
    put(1'b1, 8'h61);
    stat_is("R3 write start", 8'h89);
    check("R12 irq on obf", irq_o, 1);
    drain;
    stat_is("R11 obf cleared", 8'h88);
    check("R12 irq dropped", irq_o, 0);
    // second write lands while input-full is set
    hst_wr_i = 1'b1; hst_addr_i = 1'b0; hst_wdata_i = 8'h11;
    @(negedge clk_i);
    hst_wdata_i = 8'h22;
    stat_is("R2 ibf set", 8'h82);
    @(negedge clk_i);
    hst_wr_i = 1'b0;
    stat_is("R2 ibf cleared", 8'h81);
    drain;
    put(1'b0, 8'h33); drain;
    put(1'b1, 8'h62);
    stat_is("R4 write end", 8'h89);
    drain;
    put(1'b0, 8'h44);
    stat_is("R4 ibf held", 8'h82);
    @(negedge clk_i);
    check("R4 strobe count", req_cnt, 1);
    check("R4 length", req_len_s, 3);
    check("R4 tag", req_tag_s, 0);
    ibyte_is("R4 byte0", 0, 8'h11);
    ibyte_is("R2 dropped byte", 1, 8'h33);
    ibyte_is("R4 byte2", 2, 8'h44);
    send(2'd1, 2, 8'h90);
    stat_is("R6 stale tag ignored", 8'h82);
    send(2'd0, 3, 8'hA0);
    stat_is("R6 response accepted", 8'h41);
    check("R12 irq on response", irq_o, 1);
    data_is("R6 first byte", 8'hA0);
    put(1'b0, 8'h68); stat_is("R7 next", 8'h41); data_is("R7 byte1", 8'hA1);
    put(1'b0, 8'h68); data_is("R7 byte2", 8'hA2);
    put(1'b0, 8'h68);
    stat_is("R7 back to idle", 8'h01);
    drain;
  endtask

  task automatic t_overrun;
    put(1'b1, 8'h61); drain;
    for (int i = 0; i < 6; i++) put(1'b0, 8'h50 + 8'(i));
    put(1'b1, 8'h62);
    put(1'b0, 8'h56);
    @(negedge clk_i);
    check("R5 counted length", req_len_s, 7);
    check("R6 tag advanced", req_tag_s, 1);
    ibyte_is("R5 stored byte0", 0, 8'h50);
    ibyte_is("R5 stored byte3", 3, 8'h53);
    send(2'd1, 6, 8'hC0);
    data_is("R8 first", 8'hC0);
    put(1'b0, 8'h68); data_is("R8 second", 8'hC1);
    put(1'b0, 8'h68); data_is("R8 trunc code", 8'hCA);
    put(1'b0, 8'h68);
    stat_is("R8 ends after three", 8'h01);
    drain;
  endtask

  task automatic t_bad_read;
    put(1'b1, 8'h61); drain;
    put(1'b1, 8'h62); drain;
    put(1'b0, 8'h77);
    send(2'd2, 2, 8'hD0);
    data_is("R6 byte0", 8'hD0);
    put(1'b0, 8'h55);
    stat_is("R7 bad read byte", 8'hC1);
    drain;
    put(1'b0, 8'h00);
    stat_is("R9 error to read", 8'h41);
    data_is("R7 status 0x02", 8'h02);
    put(1'b0, 8'h68);
    stat_is("R7 idle after status", 8'h01);
    drain;
  endtask

  task automatic t_abort;
    put(1'b1, 8'h60);
    stat_is("R9 abort", 8'hC9);
    drain;
    put(1'b0, 8'h68);
    data_is("R9 abort status", 8'h01);
    put(1'b0, 8'h68);
    stat_is("R9 idle", 8'h01);
    drain;
    put(1'b1, 8'h61); drain;
    put(1'b0, 8'h12); drain;
    put(1'b1, 8'h60);
    stat_is("R9 abort in write", 8'hC9);
    drain;
    put(1'b0, 8'h68); drain;
    put(1'b0, 8'h68); drain;
  endtask

  task automatic t_bad_cmd;
    put(1'b1, 8'h62);
    stat_is("R10 bad command", 8'hC8);
    put(1'b1, 8'h60);
    stat_is("R9 abort in error", 8'hC8);
    put(1'b0, 8'h00);
    data_is("R10 status 0x02", 8'h02);
    put(1'b0, 8'h68); drain;
    put(1'b1, 8'h61); drain;
    put(1'b1, 8'h62); drain;
    put(1'b0, 8'h10);
    @(negedge clk_i);
    check("R9 tag wrap and error-abort kept", req_tag_s, 1);
    send(2'd1, 1, 8'hE0);
    data_is("R6 single byte", 8'hE0);
    put(1'b0, 8'h68);
    stat_is("R7 idle", 8'h01);
    drain;
  endtask

  task automatic t_irq;
    logic [7:0] d;
    atn_we_i = 1'b1; atn_val_i = 1'b1; atn_irq_i = 1'b1;
    @(negedge clk_i);
    atn_we_i = 1'b0;
    stat_is("R2 attention bit", 8'h04);
    check("R12 irq on attention", irq_o, 1);
    get(1'b1, d);
    check("R11 status read clears atn irq", irq_o, 0);
    stat_is("R11 flag kept", 8'h04);
    atn_we_i = 1'b1;
    @(negedge clk_i);
    atn_we_i = 1'b0;
    put(1'b1, 8'h61);
    get(1'b1, d);
    check("R12 irq held by obf", irq_o, 1);
    get(1'b0, d);
    check("R12 irq low with none pending", irq_o, 0);
    atn_we_i = 1'b1; atn_val_i = 1'b0;
    @(negedge clk_i);
    atn_we_i = 1'b0;
    stat_is("R2 attention cleared", 8'h88);
    irq_en_i = 1'b0;
    put(1'b0, 8'h11);
    stat_is("R4 obf set", 8'h81);
    check("R12 disabled irq", irq_o, 0);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset;
    t_transfer;
    t_overrun;
    t_bad_read;
    t_abort;
    t_bad_cmd;
    t_irq;
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule